// File: doc/BRIEF.md
# Serial Command Port with In-Band Status Readback

This block is the serial slave front end of a display controller. A host shifts 8-bit words into it over a clock, data and select line set. A separate data/command line tells the block what each word is. A word marked as data goes out on a one-cycle data strobe toward the display memory write port. A word marked as command goes out on a one-cycle command strobe. A "function set" command also updates the mirroring, power-down, addressing-direction and extended-mode flags, which the block holds and drives out.

One command value is special: an all-zero command word starts a readback. The block then drives its serial output through an enable, for exactly eight serial clocks, and shifts out a status byte MSB first. It then releases the output again. Because the output is undriven at all other times, the host may tie its data-in and data-out lines together. Bits the host clocks in during the readback are discarded. The block runs on a fast system clock. It synchronises the serial inputs and works from detected serial clock edges: input bits are taken on a rising edge and the output changes on a falling edge.

Top module: `serial_cmd_port`

## Requirements
- R1: While `cs_n` is low and no readback is in progress, `ser_din` is captured on each rising edge of `ser_clk`, MSB first. Eight captured bits form one word. `dc_sel` is taken together with the eighth bit.
- R2: A word taken with `dc_sel`=1 produces a single-cycle `data_valid` pulse with the word on `data_byte`. `cmd_valid` stays low for that word.
- R3: A word taken with `dc_sel`=0 and a nonzero value produces a single-cycle `cmd_valid` pulse with the word on `cmd_byte`. The value 0x00 produces no strobe at all.
- R4: A command whose bits [7:5] equal 3'b001 is a function set. It loads `flip_x`=bit4, `flip_y`=bit3, `sleep`=bit2, `vert_incr`=bit1 and `ext_mode`=bit0. Every other command leaves these five outputs unchanged.
- R5: After a 0x00 command, `dout_en` rises at the next falling edge of `ser_clk`. It stays high across the following eight rising edges and falls at the falling edge after the eighth.
- R6: During the readback, `ser_dout` presents the status byte MSB first, with one bit per `ser_clk` period. Each new bit appears at a falling edge. The byte is {sleep, flip_x, flip_y, vert_incr, ext_mode, DEV_ADDR[2:0]}, with bit 7 on the left.
- R7: Bits clocked in on `ser_din` during the eight readback clocks are ignored. They raise no strobe and change no flag. The next word after the readback is received with correct bit alignment.
- R8: Raising `cs_n` discards any partially received word and forces `dout_en` low, which ends a readback in progress. The next word after `cs_n` falls again is received from its first bit.
- R9: After reset all five flags are 0, `dout_en` is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data in |
| dc_sel | input | 1 | 1 = display data, 0 = command |
| ser_dout | output | 1 | Serial status data out |
| dout_en | output | 1 | Output driver enable for `ser_dout` (0 = high impedance) |
| cmd_valid | output | 1 | Command strobe |
| cmd_byte | output | 8 | Command word |
| data_valid | output | 1 | Display data strobe |
| data_byte | output | 8 | Display data word |
| flip_x | output | 1 | Horizontal mirror flag |
| flip_y | output | 1 | Vertical mirror flag |
| sleep | output | 1 | Power-down flag |
| vert_incr | output | 1 | Vertical addressing flag |
| ext_mode | output | 1 | Extended instruction set flag |

## Verification
Several rules are checked by assertions on every cycle:
- the driver is never enabled while the select line is high;
- no strobe appears while the output is driven;
- a command strobe never carries 0x00;
- the two strobes never coincide;
- the output bit moves only at a falling serial clock edge;
- the readback bit counter never passes eight.

The bench scenarios are needed for the rest: the decoded values, the status byte contents and order, the exact edges at which the driver turns on and off, that junk bits during a read are discarded, and that words realign after a read or an aborted transfer. The bench sweeps every data value, every command value and every flag combination through a readback.

// File: rtl/scp_pkg.sv
package scp_pkg;

   localparam int          WORD_BITS   = 8;
   localparam logic [2:0]  FSET_OPCODE = 3'b001;
   localparam logic [7:0]  READ_CMD    = 8'h00;

   typedef struct packed {
      logic flip_x;
      logic flip_y;
      logic sleep;
      logic vert_incr;
      logic ext_mode;
   } disp_flags_t;

endpackage

// File: rtl/scp_sync_edge.sv
module scp_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sdin_i,
   input  logic csn_i,
   input  logic dc_i,
   output logic sdin_o,
   output logic csn_o,
   output logic dc_o,
   output logic rise_o,
   output logic fall_o
);

   logic sclk_s;
   logic sclk_q;

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("scp_sync_edge: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign sclk_s = sclk_i;
      assign sdin_o = sdin_i;
      assign csn_o  = csn_i;
      assign dc_o   = dc_i;
   end else begin : g_sync
      // bit order {dc, csn, sdin, sclk}
      logic [3:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= 4'b0100;
         end else begin
            chain[0] <= {dc_i, csn_i, sdin_i, sclk_i};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign sclk_s = chain[STAGES-1][0];
      assign sdin_o = chain[STAGES-1][1];
      assign csn_o  = chain[STAGES-1][2];
      assign dc_o   = chain[STAGES-1][3];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign rise_o = sclk_s & ~sclk_q;
   assign fall_o = ~sclk_s & sclk_q;

endmodule

// File: rtl/scp_rx.sv
module scp_rx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   input  logic         bit_i,
   input  logic         dc_i,
   output logic         word_valid_o,
   output logic [W-1:0] word_o,
   output logic         word_dc_o
);

   localparam int CW = $clog2(W);

   logic [W-1:0]  shreg;
   logic [CW-1:0] cnt;
   logic [W-1:0]  next_word;

   if (W < 2) begin : g_bad_w
      $error("scp_rx: W must be at least 2");
   end

   assign next_word = {shreg[W-2:0], bit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg        <= '0;
         cnt          <= '0;
         word_valid_o <= 1'b0;
         word_o       <= '0;
         word_dc_o    <= 1'b0;
      end else begin
         word_valid_o <= 1'b0;
         if (clr_i) begin
            cnt <= '0;
         end else if (en_i) begin
            shreg <= next_word;
            if (cnt == CW'(W-1)) begin
               cnt          <= '0;
               word_valid_o <= 1'b1;
               word_o       <= next_word;
               word_dc_o    <= dc_i;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt == '0));

endmodule

// File: rtl/scp_tx.sv
module scp_tx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         abort_i,
   input  logic         arm_i,
   input  logic         rise_i,
   input  logic         fall_i,
   input  logic [W-1:0] status_i,
   output logic         busy_o,
   output logic         sout_o,
   output logic         oe_o
);

   localparam int RW = $clog2(W + 1);

   logic [W-1:0]  shreg;
   logic [RW-1:0] rd_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         oe_o   <= 1'b0;
         sout_o <= 1'b0;
         shreg  <= '0;
         rd_cnt <= '0;
      end else if (abort_i) begin
         busy_o <= 1'b0;
         oe_o   <= 1'b0;
         rd_cnt <= '0;
      end else begin
         if (arm_i) busy_o <= 1'b1;
         if (busy_o && oe_o && rise_i) rd_cnt <= rd_cnt + 1'b1;
         if (busy_o && fall_i) begin
            if (!oe_o) begin
               oe_o   <= 1'b1;
               sout_o <= status_i[W-1];
               shreg  <= {status_i[W-2:0], 1'b0};
               rd_cnt <= '0;
            end else if (rd_cnt == RW'(W)) begin
               oe_o   <= 1'b0;
               busy_o <= 1'b0;
            end else begin
               sout_o <= shreg[W-1];
               shreg  <= {shreg[W-2:0], 1'b0};
            end
         end
      end
   end

   // R5
   rd_cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt <= RW'(W));

   // R5
   oe_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o |-> busy_o);

   // R6
   dout_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_i |=> $stable(sout_o));

endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
   import scp_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DEV_ADDR    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              dc_sel,
   output logic              ser_dout,
   output logic              dout_en,
   output logic              cmd_valid,
   output logic [WORD_W-1:0] cmd_byte,
   output logic              data_valid,
   output logic [WORD_W-1:0] data_byte,
   output logic              flip_x,
   output logic              flip_y,
   output logic              sleep,
   output logic              vert_incr,
   output logic              ext_mode
);

   localparam int ADDR_W = WORD_W - 5;

   if (WORD_W != WORD_BITS) begin : g_bad_word
      $error("serial_cmd_port: WORD_W must be 8");
   end
   if (DEV_ADDR < 0 || DEV_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("serial_cmd_port: DEV_ADDR out of range");
   end

   logic s_din, s_csn, s_dc, s_rise, s_fall;
   logic rx_valid, rx_dc;
   logic [WORD_W-1:0] rx_word;
   logic tx_busy, read_arm;
   logic [WORD_W-1:0] status_byte;
   disp_flags_t flags;

   scp_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (ser_clk),
      .sdin_i (ser_din),
      .csn_i  (cs_n),
      .dc_i   (dc_sel),
      .sdin_o (s_din),
      .csn_o  (s_csn),
      .dc_o   (s_dc),
      .rise_o (s_rise),
      .fall_o (s_fall)
   );

   scp_rx #(.W(WORD_W)) rx_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (s_csn),
      .en_i         (s_rise & ~tx_busy),
      .bit_i        (s_din),
      .dc_i         (s_dc),
      .word_valid_o (rx_valid),
      .word_o       (rx_word),
      .word_dc_o    (rx_dc)
   );

   assign read_arm    = rx_valid & ~rx_dc & (rx_word == READ_CMD);
   assign status_byte = {flags.sleep, flags.flip_x, flags.flip_y,
                         flags.vert_incr, flags.ext_mode, ADDR_W'(DEV_ADDR)};

   scp_tx #(.W(WORD_W)) tx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort_i  (s_csn),
      .arm_i    (read_arm),
      .rise_i   (s_rise),
      .fall_i   (s_fall),
      .status_i (status_byte),
      .busy_o   (tx_busy),
      .sout_o   (ser_dout),
      .oe_o     (dout_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid  <= 1'b0;
         cmd_byte   <= '0;
         data_valid <= 1'b0;
         data_byte  <= '0;
         flags      <= '0;
      end else begin
         cmd_valid  <= 1'b0;
         data_valid <= 1'b0;
         if (rx_valid) begin
            if (rx_dc) begin
               data_valid <= 1'b1;
               data_byte  <= rx_word;
            end else if (rx_word != READ_CMD) begin
               cmd_valid <= 1'b1;
               cmd_byte  <= rx_word;
               if (rx_word[7:5] == FSET_OPCODE) flags <= rx_word[4:0];
            end
         end
      end
   end

   assign flip_x    = flags.flip_x;
   assign flip_y    = flags.flip_y;
   assign sleep     = flags.sleep;
   assign vert_incr = flags.vert_incr;
   assign ext_mode  = flags.ext_mode;

   // R3
   no_zero_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_byte != '0));

   // R2
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && data_valid));

   // R7
   quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> !(cmd_valid || data_valid));

   // R8
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_csn |=> !dout_en);

endmodule

// File: tb/serial_cmd_port_tb_top.sv
`timescale 1ns/1ps
module serial_cmd_port_tb_top;

   localparam int DEV_ADDR = 5;
   localparam int H        = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0, dc_sel = 1'b0;
   logic ser_dout, dout_en, cmd_valid, data_valid;
   logic [7:0] cmd_byte, data_byte;
   logic flip_x, flip_y, sleep, vert_incr, ext_mode;

   int n_tests = 0, n_fail = 0;
   int n_cmd = 0, n_data = 0;
   logic [7:0] last_cmd = '0, last_data = '0;
   logic [4:0] exp_flags = '0;
   bit done = 0;

   always #2 clk = ~clk;

   serial_cmd_port #(.DEV_ADDR(DEV_ADDR)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ser_clk(ser_clk),
      .ser_din(ser_din), .dc_sel(dc_sel), .ser_dout(ser_dout),
      .dout_en(dout_en), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .data_valid(data_valid), .data_byte(data_byte), .flip_x(flip_x),
      .flip_y(flip_y), .sleep(sleep), .vert_incr(vert_incr),
      .ext_mode(ext_mode)
   );

   always @(negedge clk) begin
      if (cmd_valid)  begin n_cmd++;  last_cmd  = cmd_byte;  end
      if (data_valid) begin n_data++; last_data = data_byte; end
   end

   function automatic logic [4:0] flags_now();
      return {flip_x, flip_y, sleep, vert_incr, ext_mode};
   endfunction

   function automatic logic [7:0] exp_status(logic [4:0] f);
      // f = {x, y, sleep, vert, ext}
      return {f[2], f[4], f[3], f[1], f[0], 3'(DEV_ADDR)};
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bit_out(logic b);
      ser_clk = 1'b0; ser_din = b;
      repeat (H) @(posedge clk);
      ser_clk = 1'b1;
      repeat (H) @(posedge clk);
   endtask

   task automatic send(logic dc, logic [7:0] w);
      dc_sel = dc;
      for (int i = 7; i >= 0; i--) bit_out(w[i]);
      @(negedge clk);
   endtask

   // read sequence: 0x00 then 8 clocks, junk driven on ser_din
   task automatic do_read(logic [7:0] junk, output logic [7:0] val,
                          output bit oe_ok);
      int c0;
      c0 = n_cmd;
      send(1'b0, 8'h00);
      check(n_cmd == c0, "R3 zero cmd no strobe", n_cmd, c0);
      oe_ok = 1;
      val = '0;
      for (int i = 0; i < 8; i++) begin
         ser_clk = 1'b0; ser_din = junk[7-i];
         repeat (H) @(posedge clk);
         @(negedge clk);
         if (!dout_en) oe_ok = 0;
         val[7-i] = ser_dout;
         ser_clk = 1'b1;
         repeat (H) @(posedge clk);
      end
      ser_clk = 1'b0;
      repeat (H) @(posedge clk);
      @(negedge clk);
      check(!dout_en, "R5 release after 8 clocks", dout_en, 0);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      bit ok;
      int c0, d0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      // R9 reset state
      check(flags_now() == 5'b0, "R9 flags", flags_now(), 0);
      check(!dout_en && !cmd_valid && !data_valid, "R9 outputs", dout_en, 0);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      cs_n = 1'b0;
      repeat (H) @(posedge clk);

      // R1 R2 every data value
      for (int d = 0; d < 256; d++) begin
         c0 = n_cmd; d0 = n_data;
         send(1'b1, 8'(d));
         check(n_data == d0 + 1 && last_data == 8'(d) && n_cmd == c0,
               "R2 data write", last_data, d);
      end

      // R1 R3 R4 every nonzero command value
      for (int c = 1; c < 256; c++) begin
         c0 = n_cmd; d0 = n_data;
         send(1'b0, 8'(c));
         check(n_cmd == c0 + 1 && last_cmd == 8'(c) && n_data == d0,
               "R3 command strobe", last_cmd, c);
         if (c[7:5] == 3'b001) exp_flags = c[4:0];
         check(flags_now() == exp_flags, "R4 flags", flags_now(), exp_flags);
      end

      // R5 R6 R7 read back every flag combination
      for (int f = 0; f < 32; f++) begin
         send(1'b0, 8'h20 | 8'(f));
         exp_flags = 5'(f);
         c0 = n_cmd; d0 = n_data;
         do_read(8'h3F, v, ok);
         check(ok, "R5 driver on for 8 clocks", ok, 1);
         check(v == exp_status(exp_flags), "R6 status byte", v,
               exp_status(exp_flags));
         check(n_cmd == c0 && n_data == d0, "R7 no strobe in read",
               n_cmd + n_data, c0 + d0);
         check(flags_now() == exp_flags, "R7 flags kept", flags_now(),
               exp_flags);
         send(1'b1, 8'(f) ^ 8'hA5);
         check(n_data == d0 + 1 && last_data == (8'(f) ^ 8'hA5),
               "R7 realign after read", last_data, 8'(f) ^ 8'hA5);
      end

      // R8 abort part of a word
      d0 = n_data;
      dc_sel = 1'b1;
      for (int i = 0; i < 4; i++) bit_out(1'b1);
      cs_n = 1'b1; ser_clk = 1'b0;
      repeat (H) @(posedge clk);
      cs_n = 1'b0;
      repeat (H) @(posedge clk);
      send(1'b1, 8'h5A);
      check(n_data == d0 + 1 && last_data == 8'h5A, "R8 word abort",
            last_data, 8'h5A);

      // R8 abort a read
      send(1'b0, 8'h00);
      for (int i = 0; i < 3; i++) bit_out(1'b0);
      @(negedge clk);
      check(dout_en, "R5 driver on mid read", dout_en, 1);
      cs_n = 1'b1; ser_clk = 1'b0;
      repeat (H) @(posedge clk);
      @(negedge clk);
      check(!dout_en, "R8 read abort", dout_en, 0);
      cs_n = 1'b0;
      repeat (H) @(posedge clk);
      d0 = n_data;
      send(1'b1, 8'hC3);
      check(n_data == d0 + 1 && last_data == 8'hC3, "R8 realign", last_data,
            8'hC3);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule